// File: doc/BRIEF.md
# Paged Block-Transfer SRAM Controller

This block connects a narrow host port (one 8-bit data path plus two control pins) to a 512 KB byte-wide static RAM. The host streams whole 4 KB pages in or out of the memory. It writes a control word that picks a page and a transfer direction and also rewinds an in-page byte offset to zero. Each later low pulse on the transfer pin moves one byte and then steps the offset. The block has no way to load an arbitrary byte address. To reach a byte inside a page, the host rewinds the offset and steps it forward.

Both control pins are sampled by the system clock through synchronizer chains, and all edges are detected on the synchronized levels. The memory strobes come from registers. The idle levels are transfer pin high and load pin low, and a direction bit that resets to read. With these values the memory cannot be written before the host has configured its pins. A write-protect input gates every write strobe and leaves control-word loads and reads working.

Top module: `pbx_sram_ctrl`

## Requirements
- R1: The 19-bit memory address is the 7-bit page in bits 18..12 and the 12-bit in-page offset in bits 11..0.
- R2: After reset, page, offset and direction are zero (direction 0 = read), both memory strobes are high and the block does not drive the host port.
- R3: A rising edge on `ctl_ld` loads `host_din[6:0]` as the page and `host_din[7]` as the direction (1 = host writes memory, 0 = host reads memory), and it clears the offset to zero.
- R4: While `xfer_n` is high no strobe is asserted. After `xfer_n` goes low, the strobe goes low on the third rising clock edge (two synchronizer stages plus one output register).
- R5: In write direction, `sram_we_n` is low while the synchronized `xfer_n` is low, and `sram_wdata` carries `host_din`.
- R6: The offset steps by exactly one on each synchronized rising edge of `xfer_n` that ends a transfer, so successive pulses address successive bytes.
- R7: In read direction, `sram_oe_n` is low and `host_doe` is high while the synchronized `xfer_n` is low, and `host_dout` carries `sram_rdata`. In write direction `host_doe` stays low.
- R8: While `wr_prot` is high, `sram_we_n` is never asserted and memory contents are unchanged. Control-word loads and reads still work.
- R9: From offset 4095 the next step gives offset 0, and the page does not change.
- R10: `sram_we_n` and `sram_oe_n` are never low in the same cycle. While the synchronized `ctl_ld` is high, no strobe is asserted and no offset step occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_n | input | 1 | Transfer pin: idle high, a low pulse moves one byte |
| ctl_ld | input | 1 | Load pin: idle low, rising edge loads the control word |
| wr_prot | input | 1 | Write protect: high blocks all memory writes |
| host_din | input | 8 | Byte from host: control word or write data |
| host_dout | output | 8 | Byte to host during reads |
| host_doe | output | 1 | High when the block drives the host port |
| sram_addr | output | 19 | Memory address {page, offset} |
| sram_wdata | output | 8 | Memory write data |
| sram_rdata | input | 8 | Memory read data |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |

## Verification
The assertions take for granted that the host keeps `host_din` steady from before a `ctl_ld` rise until that edge has passed the synchronizers. They also assume write data stays put until the synchronized `xfer_n` has returned high, and that `wr_prot` changes only between transfers. The stimulus tasks satisfy these assumptions by design. They set the port a cycle before they move a pin, hold every pulse phase for at least three clocks, and change data only at the start of the next pulse. The overlap case raises `ctl_ld` and lowers `xfer_n` together, then releases `xfer_n` before `ctl_ld`. No offset step can therefore fall outside the window in which the load pin dominates.

// File: rtl/pbx_pkg.sv
package pbx_pkg;
   typedef enum logic {
      XDIR_READ  = 1'b0,
      XDIR_WRITE = 1'b1
   } xfer_dir_e;
endpackage

// File: rtl/pbx_pin_sync.sv
module pbx_pin_sync #(
   parameter int STAGES = 2,
   parameter bit IDLE   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last;

   initial assert (STAGES >= 2) else $error("pbx_pin_sync: STAGES below 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{IDLE}};
         last  <= IDLE;
      end else begin
         chain <= {chain[STAGES-2:0], pin};
         last  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign rise  = chain[STAGES-1] & ~last;
endmodule

// File: rtl/pbx_addr_gen.sv
module pbx_addr_gen #(
   parameter int PAGE_W = 7,
   parameter int OFFS_W = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] ctl_word,
   input  logic              step,
   output logic [PAGE_W-1:0] page,
   output pbx_pkg::xfer_dir_e dir,
   output logic [OFFS_W-1:0] offset
);
   localparam int DIR_BIT = DATA_W - 1;

   initial assert (DATA_W >= PAGE_W + 1) else $error("pbx_addr_gen: control word too narrow");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page   <= '0;
         dir    <= pbx_pkg::XDIR_READ;
         offset <= '0;
      end else if (load) begin
         page   <= ctl_word[PAGE_W-1:0];
         dir    <= pbx_pkg::xfer_dir_e'(ctl_word[DIR_BIT]);
         offset <= '0;
      end else if (step) begin
         offset <= offset + 1'b1;
      end
   end

   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> offset == '0);

   assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && offset == {OFFS_W{1'b1}}) |=> (offset == '0 && $stable(page)));

   assert_page_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(page) && $stable(dir)));
endmodule

// File: rtl/pbx_strobe_gen.sv
module pbx_strobe_gen (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               a_level,
   input  logic               b_level,
   input  pbx_pkg::xfer_dir_e dir,
   input  logic               wp,
   output logic               we_n,
   output logic               oe_n
);
   logic xfer_act;

   assign xfer_act = ~a_level & ~b_level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_n <= 1'b1;
         oe_n <= 1'b1;
      end else begin
         we_n <= ~(xfer_act & (dir == pbx_pkg::XDIR_WRITE) & ~wp);
         oe_n <= ~(xfer_act & (dir == pbx_pkg::XDIR_READ));
      end
   end

   assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !oe_n));

   assert_bprio_R10: assert property (@(posedge clk) disable iff (!rst_n)
      b_level |=> (we_n && oe_n));

   assert_wp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wp |=> we_n);

   assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      a_level |=> (we_n && oe_n));
endmodule

// File: rtl/pbx_sram_ctrl.sv
module pbx_sram_ctrl #(
   parameter int PAGE_W      = 7,
   parameter int OFFS_W      = 12,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit WP_SYNC     = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      xfer_n,
   input  logic                      ctl_ld,
   input  logic                      wr_prot,
   input  logic [DATA_W-1:0]         host_din,
   output logic [DATA_W-1:0]         host_dout,
   output logic                      host_doe,
   output logic [PAGE_W+OFFS_W-1:0]  sram_addr,
   output logic [DATA_W-1:0]         sram_wdata,
   input  logic [DATA_W-1:0]         sram_rdata,
   output logic                      sram_we_n,
   output logic                      sram_oe_n
);
   localparam int ADDR_W = PAGE_W + OFFS_W;

   logic               a_level, a_rise;
   logic               b_level, b_rise;
   logic               wp_eff;
   logic               step;
   logic [PAGE_W-1:0]  page;
   logic [OFFS_W-1:0]  offset;
   pbx_pkg::xfer_dir_e dir;

   initial assert (ADDR_W <= 31) else $error("pbx_sram_ctrl: address too wide");

   pbx_pin_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync_a (
      .clk(clk), .rst_n(rst_n), .pin(xfer_n), .level(a_level), .rise(a_rise));

   pbx_pin_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_sync_b (
      .clk(clk), .rst_n(rst_n), .pin(ctl_ld), .level(b_level), .rise(b_rise));

   generate
      if (WP_SYNC) begin : g_wp_sync
         logic wp_edge;
         pbx_pin_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync_wp (
            .clk(clk), .rst_n(rst_n), .pin(wr_prot), .level(wp_eff), .rise(wp_edge));
      end else begin : g_wp_direct
         assign wp_eff = wr_prot;
      end
   endgenerate

   assign step = a_rise & ~b_level;

   pbx_addr_gen #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(b_rise), .ctl_word(host_din), .step(step),
      .page(page), .dir(dir), .offset(offset));

   pbx_strobe_gen u_strobe (
      .clk(clk), .rst_n(rst_n), .a_level(a_level), .b_level(b_level),
      .dir(dir), .wp(wp_eff), .we_n(sram_we_n), .oe_n(sram_oe_n));

   assign sram_addr  = {page, offset};
   assign sram_wdata = host_din;
   assign host_dout  = sram_rdata;
   assign host_doe   = ~sram_oe_n;

   assert_page_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      b_rise |=> sram_addr[ADDR_W-1:OFFS_W] == $past(host_din[PAGE_W-1:0]));

   assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rise && !b_level && !b_rise) |=>
         sram_addr[OFFS_W-1:0] == OFFS_W'($past(sram_addr[OFFS_W-1:0]) + 1'b1));

   assert_no_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (b_level && !b_rise) |=> $stable(sram_addr));

   assert_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      host_doe |-> sram_we_n);
endmodule

// File: tb/pbx_sram_ctrl_test.sv
`timescale 1ns/1ps
module pbx_sram_ctrl_test;
   localparam int S = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_pin = 1'b1;
   logic        b_pin = 1'b0;
   logic        wp = 1'b0;
   logic [7:0]  din = 8'h00;
   logic [7:0]  host_dout;
   logic        host_doe;
   logic [18:0] sram_addr;
   logic [7:0]  sram_wdata;
   logic [7:0]  sram_rdata;
   logic        sram_we_n;
   logic        sram_oe_n;

   always #2.5 clk = ~clk;

   pbx_sram_ctrl uut (
      .clk(clk), .rst_n(rst_n), .xfer_n(a_pin), .ctl_ld(b_pin), .wr_prot(wp),
      .host_din(din), .host_dout(host_dout), .host_doe(host_doe),
      .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
      .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n));

   int total = 0;
   int bad = 0;
   bit run_chk = 1'b0;
   int we_lows = 0;
   logic [7:0] last_rd = 8'h00;

   // memory environment
   byte unsigned mem[int];
   int mem_gen = 0;
   always @(posedge clk)
      if (rst_n && !sram_we_n) begin
         mem[int'(sram_addr)] = sram_wdata;
         mem_gen++;
      end
   always @(sram_addr or mem_gen)
      sram_rdata = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;

   // behavioural reference model
   int ma[S];
   int mb[S];
   int m_ap, m_bp, m_page, m_dir, m_off, m_we, m_oe;
   byte unsigned shadow[int];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < S; i++) begin ma[i] = 1; mb[i] = 0; end
         m_ap = 1; m_bp = 0; m_page = 0; m_dir = 0; m_off = 0; m_we = 1; m_oe = 1;
      end else begin
         int as_v, bs_v, nwe, noe;
         bit act;
         as_v = ma[S-1];
         bs_v = mb[S-1];
         if (m_we == 0) shadow[m_page * 4096 + m_off] = din;
         act = (as_v == 0) && (bs_v == 0);
         nwe = (act && m_dir == 1 && wp == 1'b0) ? 0 : 1;
         noe = (act && m_dir == 0) ? 0 : 1;
         if (bs_v == 1 && m_bp == 0) begin
            m_page = int'(din) % 128;
            m_dir = int'(din) / 128;
            m_off = 0;
         end else if (as_v == 1 && m_ap == 0 && bs_v == 0) begin
            m_off = (m_off + 1) % 4096;
         end
         m_ap = as_v;
         m_bp = bs_v;
         for (int i = S - 1; i > 0; i--) begin ma[i] = ma[i-1]; mb[i] = mb[i-1]; end
         ma[0] = int'(a_pin);
         mb[0] = int'(b_pin);
         m_we = nwe;
         m_oe = noe;
      end
   end

   task automatic chk(input string req, input int act, input int exp, input string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && run_chk) begin
         int ea;
         ea = m_page * 4096 + m_off;
         chk("R1", int'(sram_addr), ea, "address");
         chk("R5", int'(sram_we_n), m_we, "write strobe");
         chk("R7", int'(sram_oe_n), m_oe, "output enable");
         chk("R7", int'(host_doe), (m_oe == 0) ? 1 : 0, "host drive");
         if (!sram_we_n) chk("R5", int'(sram_wdata), int'(din), "write data");
         if (m_oe == 0) chk("R7", int'(host_dout), shadow.exists(ea) ? int'(shadow[ea]) : 0, "read data");
      end
      if (rst_n && !sram_we_n) we_lows++;
      if (rst_n && host_doe) last_rd = host_dout;
   end

   task automatic tick(input int n);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic ctl_word(input logic [7:0] w);
      din = w; tick(1);
      b_pin = 1'b1; tick(4);
      b_pin = 1'b0; tick(4);
   endtask

   task automatic pulse(input logic [7:0] d);
      din = d; tick(1);
      a_pin = 1'b0; tick(3);
      a_pin = 1'b1; tick(4);
   endtask

   logic [7:0] vals[6];

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 6; i++) vals[i] = 8'(8'h30 + i * 7);
      tick(3);
      chk("R2", int'(sram_we_n), 1, "reset we_n");
      chk("R2", int'(sram_oe_n), 1, "reset oe_n");
      chk("R2", int'(host_doe), 0, "reset drive");
      rst_n = 1'b1;
      tick(2);
      chk("R2", int'(sram_addr), 0, "reset address");
      run_chk = 1'b1;

      // write page 5 with latency check on the first pulse
      ctl_word(8'h85);
      chk("R3", int'(sram_addr), 5 * 4096, "page load");
      din = vals[0]; tick(1);
      a_pin = 1'b0; tick(2);
      chk("R4", int'(sram_we_n), 1, "strobe before third edge");
      tick(1);
      chk("R4", int'(sram_we_n), 0, "strobe at third edge");
      a_pin = 1'b1; tick(4);
      for (int i = 1; i < 6; i++) pulse(vals[i]);
      chk("R6", int'(sram_addr), 5 * 4096 + 6, "offset after six pulses");
      tick(10);
      chk("R4", int'(sram_we_n) + int'(sram_oe_n), 2, "idle pin no strobe");

      // read page 5 back
      ctl_word(8'h05);
      for (int i = 0; i < 6; i++) begin
         pulse(8'h00);
         chk("R7", int'(last_rd), int'(vals[i]), "readback");
      end

      // write protect
      wp = 1'b1;
      begin
         int w0;
         w0 = we_lows;
         ctl_word(8'h85);
         chk("R8", int'(sram_addr), 5 * 4096, "load under protect");
         for (int i = 0; i < 3; i++) pulse(8'hEE);
         chk("R8", we_lows, w0, "no write strobes");
         ctl_word(8'h05);
         for (int i = 0; i < 3; i++) begin
            pulse(8'h00);
            chk("R8", int'(last_rd), int'(vals[i]), "protected data");
         end
      end
      wp = 1'b0;

      // load pin dominates an overlapping transfer
      ctl_word(8'h82);
      pulse(8'h11);
      pulse(8'h22);
      chk("R6", int'(sram_addr), 2 * 4096 + 2, "offset two");
      begin
         int w1;
         w1 = we_lows;
         din = 8'h82; tick(1);
         a_pin = 1'b0; b_pin = 1'b1; tick(5);
         a_pin = 1'b1; tick(5);
         b_pin = 1'b0; tick(4);
         chk("R10", we_lows, w1, "no strobe while load active");
         chk("R10", int'(sram_addr), 2 * 4096, "cleared and not stepped");
      end

      // full page sweep with wrap
      ctl_word(8'h83);
      for (int i = 0; i < 4096; i++) pulse(8'(i));
      chk("R9", int'(sram_addr), 3 * 4096, "wrap to page start");
      pulse(8'h5A);
      chk("R9", int'(sram_addr), 3 * 4096 + 1, "step after wrap");

      tick(4);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule